// File: doc/BRIEF.md
# Physical memory access permission checker

This block decides whether one memory access may proceed. A request gives an address, a byte count, the set of read, write and execute rights the access needs, and whether the hart is in machine mode. The block holds no state of its own. It reads a bank of protection entries supplied from outside. Each entry has an inclusive low and high byte bound and a configuration byte. The block also reads three security-policy bits and a global enable.

The block compares the first and the last byte of the access against every active entry in parallel. It then takes the lowest-numbered entry that touches the access. An access that straddles the edge of that entry is refused outright. An access fully inside the entry gets its grant from one of two sets of rules:
- the classic rules, or
- a 16-way lockdown truth table, used when the lockdown policy bit is set. The table has separate columns for machine mode and the lower modes.

When no entry touches the access, a default policy applies. It depends on the whitelist bit, the lockdown bit and the mode. The result is registered: one cycle after a request-valid pulse, a response-valid pulse carries the allow bit and the granted read/write/execute mask.

Top module: `pmp_access_checker`

## Requirements
- R1: `rsp_valid` is high exactly in the cycle after a cycle with `req_valid` high, and `rsp_allow` and `rsp_grant` in that cycle give the verdict for the inputs present in the request cycle.
- R2: Entries have a fixed priority, with index 0 highest. The lowest-indexed active entry that contains the first or the last byte of the access decides the result, and all entries after it are ignored.
- R3: If exactly one of the first byte (`req_addr`) and the last byte (`req_addr + size - 1`, modulo 2^ADDR_W) lies in `[lo, hi]` of the deciding entry, the access is refused with `rsp_grant` = 0.
- R4: Configuration byte layout: bit 0 read, bit 1 write, bit 2 execute, bits 4:3 match mode, bit 7 lock. With `sec_mml` low and a full match, machine mode gets all three rights when the entry is unlocked. Otherwise the grant is the entry's bits 2:0. An entry counts as locked when bit 7 is set and `sec_rlb` is low.
- R5: With `sec_mml` high, a full match in machine mode looks up the index {lock, read, write, execute} (lock is the most significant bit). Indexes 2, 3 and 14 grant read+write. Indexes 9 and 10 grant execute. Indexes 11 and 13 grant read+execute. Indexes 12 and 15 grant read. Every other index grants nothing.
- R6: With `sec_mml` high, a full match in a lower mode uses the same index. Indexes 1, 10 and 11 grant execute. Indexes 2, 4 and 15 grant read. Indexes 3 and 6 grant read+write. Index 5 grants read+execute. Index 7 grants all three rights. Every other index grants nothing.
- R7: With no match and `sec_mmwp` high, every mode is refused with an empty grant.
- R8: With no match, `sec_mmwp` low and `sec_mml` high, machine mode is granted read+write and lower modes are refused with an empty grant.
- R9: With no match and both policy bits low, machine mode is granted all three rights, and so is every mode when `prot_en` is low. Lower modes with `prot_en` high are refused with an empty grant.
- R10: `rsp_grant` bit 0 is read, bit 1 write and bit 2 execute, and `req_perm` uses the same bit positions. The access is allowed only when every requested bit is present in the grant. A no-match case with an empty grant, and a straddling access, are refused even when nothing is requested.
- R11: A `req_size` of zero means the hart's natural width: 4 bytes when XLEN is 32, and 8 bytes when XLEN is 64.
- R12: While `rst_n` is low, `rsp_valid`, `rsp_allow` and `rsp_grant` are all zero.
- R13: An entry whose match mode (bits 4:3) is 00 is inactive and never matches. All entries are inactive while `prot_en` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request strobe |
| req_addr | input | ADDR_W | First byte address of the access |
| req_size | input | SIZE_W | Byte count; zero selects the natural width |
| req_perm | input | 3 | Requested rights {X,W,R} |
| req_mmode | input | 1 | Request is made in machine mode |
| ent_lo | input | NUM_ENTRIES*ADDR_W | Inclusive low byte bound per entry, entry i at slice i |
| ent_hi | input | NUM_ENTRIES*ADDR_W | Inclusive high byte bound per entry |
| ent_cfg | input | NUM_ENTRIES*8 | Configuration byte per entry |
| prot_en | input | 1 | Protection entries implemented and enabled |
| sec_mml | input | 1 | Lockdown policy bit |
| sec_mmwp | input | 1 | Whitelist (deny on no match) policy bit |
| sec_rlb | input | 1 | Lock bypass: lock bits are treated as clear |
| rsp_valid | output | 1 | Response strobe, one cycle after `req_valid` |
| rsp_allow | output | 1 | Access allowed |
| rsp_grant | output | 3 | Granted rights {X,W,R} |

## Verification
The block keeps no state across requests, so any internal fault shows up in the very response it corrupts, one cycle after the request. Examples are a wrong priority pick, a wrong last-byte sum or a mis-wired table index. The bench therefore compares every response against a reference verdict. It sweeps all 16 table indexes in both modes. It also hits the straddle, size-zero and inactive-entry corners, because a fault in those narrow paths would otherwise hide behind a neighbouring entry or behind the default policy.

// File: rtl/pmp_access_checker.sv
module pmp_access_checker #(
  parameter int NUM_ENTRIES = 8,
  parameter int ADDR_W      = 32,
  parameter int XLEN        = 32,
  parameter int SIZE_W      = 4
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          req_valid,
  input  logic [ADDR_W-1:0]             req_addr,
  input  logic [SIZE_W-1:0]             req_size,
  input  logic [2:0]                    req_perm,
  input  logic                          req_mmode,
  input  logic [NUM_ENTRIES*ADDR_W-1:0] ent_lo,
  input  logic [NUM_ENTRIES*ADDR_W-1:0] ent_hi,
  input  logic [NUM_ENTRIES*8-1:0]      ent_cfg,
  input  logic                          prot_en,
  input  logic                          sec_mml,
  input  logic                          sec_mmwp,
  input  logic                          sec_rlb,
  output logic                          rsp_valid,
  output logic                          rsp_allow,
  output logic [2:0]                    rsp_grant
);
  localparam int NAT_BYTES = XLEN / 8;
  localparam int IDX_W     = (NUM_ENTRIES > 1) ? $clog2(NUM_ENTRIES) : 1;
  localparam logic [2:0] G_NONE = 3'b000;
  localparam logic [2:0] G_R    = 3'b001;
  localparam logic [2:0] G_RW   = 3'b011;
  localparam logic [2:0] G_X    = 3'b100;
  localparam logic [2:0] G_RX   = 3'b101;
  localparam logic [2:0] G_RWX  = 3'b111;

  function automatic logic [2:0] tab_machine(input logic [3:0] idx);
    case (idx)
      4'd2, 4'd3, 4'd14:  tab_machine = G_RW;
      4'd9, 4'd10:        tab_machine = G_X;
      4'd11, 4'd13:       tab_machine = G_RX;
      4'd12, 4'd15:       tab_machine = G_R;
      default:            tab_machine = G_NONE;
    endcase
  endfunction

  function automatic logic [2:0] tab_lower(input logic [3:0] idx);
    case (idx)
      4'd1, 4'd10, 4'd11: tab_lower = G_X;
      4'd2, 4'd4, 4'd15:  tab_lower = G_R;
      4'd3, 4'd6:         tab_lower = G_RW;
      4'd5:               tab_lower = G_RX;
      4'd7:               tab_lower = G_RWX;
      default:            tab_lower = G_NONE;
    endcase
  endfunction

  logic [ADDR_W-1:0] eff_size, last_addr;
  assign eff_size  = (req_size == '0) ? ADDR_W'(NAT_BYTES) : ADDR_W'(req_size);
  assign last_addr = req_addr + eff_size - ADDR_W'(1);

  logic [NUM_ENTRIES-1:0] full_hit, part_hit;

  for (genvar i = 0; i < NUM_ENTRIES; i++) begin : g_ent
    logic [ADDR_W-1:0] lo, hi;
    logic              active, in_first, in_last;
    assign lo       = ent_lo[i*ADDR_W +: ADDR_W];
    assign hi       = ent_hi[i*ADDR_W +: ADDR_W];
    assign active   = prot_en && (ent_cfg[i*8+3 +: 2] != 2'b00);
    assign in_first = (req_addr >= lo) && (req_addr <= hi);
    assign in_last  = (last_addr >= lo) && (last_addr <= hi);
    assign full_hit[i] = active && in_first && in_last;
    assign part_hit[i] = active && (in_first ^ in_last);
  end

  logic             hit, straddle;
  logic [IDX_W-1:0] sel;

  always_comb begin
    hit      = 1'b0;
    straddle = 1'b0;
    sel      = '0;
    for (int i = NUM_ENTRIES - 1; i >= 0; i--) begin
      if (full_hit[i] || part_hit[i]) begin
        hit      = 1'b1;
        straddle = part_hit[i];
        sel      = IDX_W'(i);
      end
    end
  end

  logic [7:0] sel_cfg;
  logic       sel_locked;
  logic [3:0] tab_idx;
  logic [2:0] classic_grant, table_grant, match_grant, dflt_grant, grant;
  logic       forced_deny, allow;

  assign sel_cfg    = ent_cfg[sel*8 +: 8];
  assign sel_locked = sel_cfg[7] && !sec_rlb;
  assign tab_idx    = {sel_cfg[7], sel_cfg[0], sel_cfg[1], sel_cfg[2]};

  assign classic_grant = (req_mmode && !sel_locked) ? G_RWX : sel_cfg[2:0];
  assign table_grant   = req_mmode ? tab_machine(tab_idx) : tab_lower(tab_idx);
  assign match_grant   = straddle ? G_NONE : (sec_mml ? table_grant : classic_grant);

  always_comb begin
    if (sec_mmwp)                    dflt_grant = G_NONE;
    else if (sec_mml)                dflt_grant = req_mmode ? G_RW : G_NONE;
    else if (req_mmode || !prot_en)  dflt_grant = G_RWX;
    else                             dflt_grant = G_NONE;
  end

  assign grant       = hit ? match_grant : dflt_grant;
  assign forced_deny = hit ? straddle : (dflt_grant == G_NONE);
  assign allow       = !forced_deny && ((req_perm & ~grant) == 3'b000);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_allow <= 1'b0;
      rsp_grant <= G_NONE;
    end else begin
      rsp_valid <= req_valid;
      if (req_valid) begin
        rsp_allow <= allow;
        rsp_grant <= grant;
      end
    end
  end
endmodule

module pmp_access_checker_sva #(
  parameter int NUM_ENTRIES = 8,
  parameter int ADDR_W      = 32
) (
  input logic                     clk,
  input logic                     rst_n,
  input logic                     req_valid,
  input logic [2:0]               req_perm,
  input logic                     req_mmode,
  input logic [NUM_ENTRIES*8-1:0] ent_cfg,
  input logic                     prot_en,
  input logic                     sec_mml,
  input logic                     sec_mmwp,
  input logic                     rsp_valid,
  input logic                     rsp_allow,
  input logic [2:0]               rsp_grant
);
  logic none_active;
  always_comb begin
    none_active = 1'b1;
    for (int i = 0; i < NUM_ENTRIES; i++)
      if (prot_en && ent_cfg[i*8+3 +: 2] != 2'b00) none_active = 1'b0;
  end

  p_rsp_follows_req_r1: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> rsp_valid);
  p_no_spurious_rsp_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> !rsp_valid);
  p_allow_covers_request_r10: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> (!rsp_allow || ((req_perm_q & ~rsp_grant) == 3'b000)));
  p_machine_table_no_rwx_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && sec_mml && req_mmode) |=> (rsp_grant != 3'b111));
  p_whitelist_empty_deny_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && sec_mmwp && none_active) |=> (!rsp_allow && rsp_grant == 3'b000));
  p_lower_default_deny_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && none_active && prot_en && !req_mmode) |=> (rsp_grant == 3'b000 && !rsp_allow));

  logic [2:0] req_perm_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) req_perm_q <= 3'b000;
    else        req_perm_q <= req_perm;
  end
endmodule

bind pmp_access_checker pmp_access_checker_sva #(
  .NUM_ENTRIES(NUM_ENTRIES),
  .ADDR_W(ADDR_W)
) chk_i (
  .clk(clk),
  .rst_n(rst_n),
  .req_valid(req_valid),
  .req_perm(req_perm),
  .req_mmode(req_mmode),
  .ent_cfg(ent_cfg),
  .prot_en(prot_en),
  .sec_mml(sec_mml),
  .sec_mmwp(sec_mmwp),
  .rsp_valid(rsp_valid),
  .rsp_allow(rsp_allow),
  .rsp_grant(rsp_grant)
);

// File: tb/pmp_access_checker_tb_top.sv
`timescale 1ns/1ps
module pmp_access_checker_tb_top;
  localparam int N  = 8;
  localparam int AW = 32;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          req_valid = 1'b0;
  logic [AW-1:0] req_addr = '0;
  logic [3:0]    req_size = '0;
  logic [2:0]    req_perm = '0;
  logic          req_mmode = 1'b0;
  logic          prot_en = 1'b1, sec_mml = 1'b0, sec_mmwp = 1'b0, sec_rlb = 1'b0;
  logic [AW-1:0] lo_a [N];
  logic [AW-1:0] hi_a [N];
  logic [7:0]    cfg_a [N];
  logic [N*AW-1:0] ent_lo, ent_hi;
  logic [N*8-1:0]  ent_cfg;
  logic          rsp_valid, rsp_allow;
  logic [2:0]    rsp_grant;
  int n_chk = 0, n_bad = 0;

  always #4 clk = ~clk;

  always_comb begin
    for (int i = 0; i < N; i++) begin
      ent_lo[i*AW +: AW] = lo_a[i];
      ent_hi[i*AW +: AW] = hi_a[i];
      ent_cfg[i*8 +: 8]  = cfg_a[i];
    end
  end

  pmp_access_checker dut_i (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_addr(req_addr),
    .req_size(req_size), .req_perm(req_perm), .req_mmode(req_mmode),
    .ent_lo(ent_lo), .ent_hi(ent_hi), .ent_cfg(ent_cfg), .prot_en(prot_en),
    .sec_mml(sec_mml), .sec_mmwp(sec_mmwp), .sec_rlb(sec_rlb),
    .rsp_valid(rsp_valid), .rsp_allow(rsp_allow), .rsp_grant(rsp_grant));

  // Lockdown table; index = {L,R,W,X}; result {X,W,R}
  function automatic logic [2:0] ref_table(input logic mm, input int idx);
    if (mm) begin
      if (idx inside {2, 3, 14}) return 3'b011;
      if (idx inside {9, 10})    return 3'b100;
      if (idx inside {11, 13})   return 3'b101;
      if (idx inside {12, 15})   return 3'b001;
      return 3'b000;
    end
    if (idx inside {1, 10, 11}) return 3'b100;
    if (idx inside {2, 4, 15})  return 3'b001;
    if (idx inside {3, 6})      return 3'b011;
    if (idx == 5)               return 3'b101;
    if (idx == 7)               return 3'b111;
    return 3'b000;
  endfunction

  function automatic logic [3:0] ref_model(input logic [AW-1:0] a, input logic [3:0] sz,
                                           input logic [2:0] pm, input logic mm);
    logic [AW-1:0] last;
    logic f, l;
    logic [2:0] g;
    last = a + ((sz == 0) ? 32'd4 : {28'd0, sz}) - 32'd1;
    for (int i = 0; i < N; i++) begin
      if (prot_en && cfg_a[i][4:3] != 2'b00) begin
        f = (a >= lo_a[i]) && (a <= hi_a[i]);
        l = (last >= lo_a[i]) && (last <= hi_a[i]);
        if (f != l) return 4'b0000;
        if (f) begin
          if (sec_mml)
            g = ref_table(mm, {cfg_a[i][7], cfg_a[i][0], cfg_a[i][1], cfg_a[i][2]});
          else if (mm && !(cfg_a[i][7] && !sec_rlb))
            g = 3'b111;
          else
            g = cfg_a[i][2:0];
          return {((pm & ~g) == 3'b000), g};
        end
      end
    end
    if (sec_mmwp)                g = 3'b000;
    else if (sec_mml)            g = mm ? 3'b011 : 3'b000;
    else if (mm || !prot_en)     g = 3'b111;
    else                         g = 3'b000;
    return {(g != 3'b000) && ((pm & ~g) == 3'b000), g};
  endfunction

  task automatic check(input string req, input logic [3:0] act, input logic [3:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual allow/grant=%b expected=%b", req, act, exp);
    end
  endtask

  task automatic run(input string req, input logic [AW-1:0] a, input logic [3:0] sz,
                     input logic [2:0] pm, input logic mm);
    logic [3:0] exp;
    exp = ref_model(a, sz, pm, mm);
    @(negedge clk);
    req_addr = a; req_size = sz; req_perm = pm; req_mmode = mm; req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    check({req, " R1 valid"}, {3'b000, rsp_valid}, 4'b0001);
    check(req, {rsp_allow, rsp_grant}, exp);
  endtask

  task automatic clear_entries();
    for (int i = 0; i < N; i++) begin
      lo_a[i] = '0; hi_a[i] = '0; cfg_a[i] = '0;
    end
  endtask

  initial begin
    #(8ns * 200000);
    n_bad++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    clear_entries();
    #20;
    check("R12 reset", {rsp_allow, rsp_grant}, 4'b0000);
    check("R12 reset valid", {3'b000, rsp_valid}, 4'b0000);
    @(negedge clk); rst_n = 1'b1;

    // R2 priority: entry0 R on 0x40..0x4F, entry1 RWX on 0..0xFF
    lo_a[0] = 32'h40; hi_a[0] = 32'h4F; cfg_a[0] = 8'h09;
    lo_a[1] = 32'h00; hi_a[1] = 32'hFF; cfg_a[1] = 8'h0F;
    run("R2 read", 32'h44, 4'd4, 3'b001, 1'b0);
    check("R2 read grant", {rsp_allow, rsp_grant}, 4'b1001);
    run("R2 write", 32'h44, 4'd4, 3'b010, 1'b0);
    check("R2 write grant", {rsp_allow, rsp_grant}, 4'b0001);
    @(negedge clk);
    check("R1 idle", {3'b000, rsp_valid}, 4'b0000);

    // R3 straddle
    clear_entries();
    lo_a[0] = 32'h10; hi_a[0] = 32'h1F; cfg_a[0] = 8'h0B;
    run("R3 straddle", 32'h1C, 4'd8, 3'b000, 1'b1);
    check("R3 straddle", {rsp_allow, rsp_grant}, 4'b0000);

    // R11 size zero = 4 bytes
    lo_a[0] = 32'h10; hi_a[0] = 32'h13; cfg_a[0] = 8'h09;
    run("R11 fit", 32'h10, 4'd0, 3'b001, 1'b0);
    check("R11 fit", {rsp_allow, rsp_grant}, 4'b1001);
    run("R11 over", 32'h11, 4'd0, 3'b001, 1'b0);
    check("R11 over", {rsp_allow, rsp_grant}, 4'b0000);

    // R13 inactive entry
    cfg_a[0] = 8'h07; lo_a[0] = 32'h0; hi_a[0] = 32'hFF;
    run("R13 inactive", 32'h20, 4'd4, 3'b001, 1'b0);
    check("R13 inactive", {rsp_allow, rsp_grant}, 4'b0000);

    // R4 classic: lock and bypass
    cfg_a[0] = 8'h89;
    run("R4 locked M", 32'h20, 4'd4, 3'b010, 1'b1);
    check("R4 locked M", {rsp_allow, rsp_grant}, 4'b0001);
    sec_rlb = 1'b1;
    run("R4 bypass M", 32'h20, 4'd4, 3'b010, 1'b1);
    check("R4 bypass M", {rsp_allow, rsp_grant}, 4'b1111);
    sec_rlb = 1'b0;

    // R5 / R6 full table sweep
    sec_mml = 1'b1;
    for (int m = 0; m < 2; m++) begin
      for (int idx = 0; idx < 16; idx++) begin
        cfg_a[0] = {idx[3], 2'b00, 2'b01, idx[0], idx[1], idx[2]};
        run(m ? "R5 table" : "R6 table", 32'h20, 4'd4, 3'b000, m[0]);
      end
    end

    // R7 / R8 / R9 defaults
    clear_entries();
    run("R8 M", 32'h20, 4'd4, 3'b011, 1'b1);
    check("R8 M", {rsp_allow, rsp_grant}, 4'b1011);
    run("R8 M exec", 32'h20, 4'd4, 3'b100, 1'b1);
    sec_mmwp = 1'b1;
    run("R7 M", 32'h20, 4'd4, 3'b000, 1'b1);
    check("R7 M", {rsp_allow, rsp_grant}, 4'b0000);
    sec_mmwp = 1'b0; sec_mml = 1'b0;
    run("R9 M", 32'h20, 4'd4, 3'b111, 1'b1);
    check("R9 M", {rsp_allow, rsp_grant}, 4'b1111);
    run("R9 lower", 32'h20, 4'd4, 3'b000, 1'b0);
    check("R9 lower R10 empty", {rsp_allow, rsp_grant}, 4'b0000);
    prot_en = 1'b0;
    run("R9 disabled", 32'h20, 4'd4, 3'b101, 1'b0);
    check("R9 disabled", {rsp_allow, rsp_grant}, 4'b1111);
    prot_en = 1'b1;

    // Random mix (R2, R3, R4, R10)
    for (int k = 0; k < 3000; k++) begin
      if (k % 20 == 0) begin
        for (int i = 0; i < N; i++) begin
          lo_a[i]  = $urandom_range(0, 200);
          hi_a[i]  = lo_a[i] + $urandom_range(0, 40);
          cfg_a[i] = 8'($urandom);
        end
        sec_mml  = ($urandom_range(0, 3) == 0);
        sec_mmwp = ($urandom_range(0, 5) == 0);
        sec_rlb  = ($urandom_range(0, 3) == 0);
        prot_en  = ($urandom_range(0, 9) != 0);
      end
      run("R10 random", 32'($urandom_range(0, 255)), 4'($urandom), 3'($urandom), 1'($urandom));
    end

    rst_n = 1'b0;
    #1;
    check("R12 reset again", {rsp_valid, rsp_allow, rsp_grant[1:0]}, 4'b0000);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule